// File: doc/BRIEF.md
# Vsync-Latched Frame Base Address Registers

This block holds the frame-buffer start addresses that a display DMA engine reads from. It has one address per panel, with two panels by default: panel 0 is the upper panel and panel 1 is the lower panel. Each panel address exists twice. A software copy is written through a simple register port. An active copy drives the address generator. Software can rewrite its copies at any time, including in the middle of a frame, and the frame being fetched is not affected.

On a vertical-sync event, while the display is enabled, every software copy moves into its active copy in the same clock. The event also sets a sticky update flag. The flag tells software that both addresses can be reprogrammed safely for the next frame, which is how double-buffered video is driven. When an enable bit is set, the flag also drives a level-sensitive interrupt output.

The register offsets are 0x10 for the upper base, 0x14 for the lower base, 0x18 for the interrupt enable (bit 0), 0x1C for the update flag (bit 0, read only) and 0x20 for the flag clear (write 1 to bit 0). Reads are combinational on the address port.

Top module: `fbase_top`

## Requirements
- R1: After reset, all software copies, active copies, the interrupt enable, the update flag and `irq` are zero.
- R2: Base addresses are word aligned. Bits 1:0 of a written base value are discarded, so they read back as zero at 0x10/0x14 and are zero on `active_base`.
- R3: A write to 0x10 or 0x14 can be read back in the next cycle. `active_base` does not change until a vertical-sync copy.
- R4: When `vsync` is high and `disp_en` is high at a clock edge, both software copies are loaded into `active_base` at that edge. Upper is in bits 31:0 and lower is in bits 63:32.
- R5: If a base write and a vsync copy occur at the same edge, the active copy takes the value held before the write. The new value becomes active at the following vsync.
- R6: Each vsync copy sets the update flag (`base_upd`, and bit 0 at 0x1C). The flag stays set until it is cleared.
- R7: Writing 1 to bit 0 of 0x20 clears the flag. Writing 0 there leaves the flag unchanged.
- R8: If a clear write and a vsync copy occur at the same edge, the flag ends up set.
- R9: `irq` is high exactly when the update flag is set and bit 0 of 0x18 is set.
- R10: While `disp_en` is low, `vsync` has no effect: `active_base` keeps its last loaded value and the flag is not set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 8 | Byte offset for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| disp_en | input | 1 | Display controller enable; vsync copies happen only while high |
| vsync | input | 1 | Vertical-sync event, one cycle per frame |
| active_base | output | 64 | Active base addresses; panel 0 (upper) in bits 31:0, panel 1 (lower) in bits 63:32 |
| base_upd | output | 1 | Sticky update flag |
| irq | output | 1 | Level interrupt: update flag ANDed with the enable bit |

## Verification
The bench builds the block with its default parameters: two panels, two alignment bits and a register window starting at 0x10. This puts the upper/lower split of the active bus and the fixed offsets 0x10 through 0x20 in reach of directed tests. With these values the bench can drive a write and a vsync at the same edge. It can also collide a clear with a set, and issue a vsync while the display is disabled. In each case the expected active value and flag state can be stated exactly one edge later.

// File: rtl/fbase_pkg.sv
`timescale 1ns/1ps
package fbase_pkg;

    localparam int WORD_W = 32;
    localparam int ADDR_W = 8;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    // Decoded target of a register access
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_BASE,
        SEL_MASK,
        SEL_STAT,
        SEL_CLR
    } sel_e;

    // Clear the low alignment bits of a base value
    function automatic word_t align_word(input word_t w, input int unsigned lsb);
        word_t keep;
        keep = ~((word_t'(1) << lsb) - word_t'(1));
        return w & keep;
    endfunction

    // Byte offset of slot n in a word-spaced window
    function automatic addr_t slot_offset(input int unsigned base, input int unsigned n);
        return addr_t'(base + 4 * n);
    endfunction

endpackage

// File: rtl/fbase_decode.sv
`timescale 1ns/1ps
module fbase_decode
    import fbase_pkg::*;
#(
    parameter int NUM_PANELS = 2,
    parameter int BASE_OFF   = 16,
    parameter int IDX_W      = 1
) (
    input  addr_t            addr,
    output sel_e             sel,
    output logic [IDX_W-1:0] idx
);
    localparam int MASK_OFF = BASE_OFF + 4 * NUM_PANELS;
    localparam int STAT_OFF = MASK_OFF + 4;
    localparam int CLR_OFF  = STAT_OFF + 4;

    always_comb begin
        sel = SEL_NONE;
        idx = '0;
        for (int i = 0; i < NUM_PANELS; i++) begin
            if (addr == slot_offset(BASE_OFF, i)) begin
                sel = SEL_BASE;
                idx = IDX_W'(i);
            end
        end
        if (addr == addr_t'(MASK_OFF)) sel = SEL_MASK;
        if (addr == addr_t'(STAT_OFF)) sel = SEL_STAT;
        if (addr == addr_t'(CLR_OFF))  sel = SEL_CLR;
    end
endmodule

// File: rtl/fbase_bank.sv
`timescale 1ns/1ps
module fbase_bank
    import fbase_pkg::*;
#(
    parameter int NUM_PANELS = 2,
    parameter int ALIGN_BITS = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_PANELS-1:0] we,
    input  word_t                 wdata,
    input  logic                  load,
    output word_t                 shadow [NUM_PANELS],
    output word_t                 active [NUM_PANELS]
);
    word_t wdata_al;
    assign wdata_al = align_word(wdata, ALIGN_BITS);

    for (genvar p = 0; p < NUM_PANELS; p++) begin : g_panel
        word_t sh_q, ac_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                sh_q <= '0;
                ac_q <= '0;
            end else begin
                if (we[p]) sh_q <= wdata_al;
                // the active copy takes the value held before this edge
                if (load)  ac_q <= sh_q;
            end
        end

        assign shadow[p] = sh_q;
        assign active[p] = ac_q;
    end
endmodule

// File: rtl/fbase_status.sv
`timescale 1ns/1ps
module fbase_status (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    input  logic mask_we,
    input  logic mask_wbit,
    output logic flag,
    output logic mask,
    output logic irq
);
    logic flag_q, mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            mask_q <= 1'b0;
        end else begin
            if (set)      flag_q <= 1'b1;   // a set outranks a clear
            else if (clr) flag_q <= 1'b0;
            if (mask_we)  mask_q <= mask_wbit;
        end
    end

    assign flag = flag_q;
    assign mask = mask_q;
    assign irq  = flag_q & mask_q;
endmodule

// File: rtl/fbase_top.sv
`timescale 1ns/1ps
module fbase_top
    import fbase_pkg::*;
#(
    parameter int NUM_PANELS = 2,
    parameter int ALIGN_BITS = 2,
    parameter int BASE_OFF   = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         bus_wr,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [WORD_W-1:0]            bus_wdata,
    output logic [WORD_W-1:0]            bus_rdata,
    input  logic                         disp_en,
    input  logic                         vsync,
    output logic [NUM_PANELS*WORD_W-1:0] active_base,
    output logic                         base_upd,
    output logic                         irq
);
    localparam int IDX_W   = (NUM_PANELS > 1) ? $clog2(NUM_PANELS) : 1;
    localparam int CLR_OFF = BASE_OFF + 4 * NUM_PANELS + 8;

    sel_e             sel;
    logic [IDX_W-1:0] idx;
    logic [NUM_PANELS-1:0] base_we;
    logic             copy_evt;
    logic             flag, mask;
    word_t            shadow [NUM_PANELS];
    word_t            active [NUM_PANELS];

    fbase_decode #(
        .NUM_PANELS(NUM_PANELS),
        .BASE_OFF  (BASE_OFF),
        .IDX_W     (IDX_W)
    ) u_dec (
        .addr(bus_addr),
        .sel (sel),
        .idx (idx)
    );

    for (genvar p = 0; p < NUM_PANELS; p++) begin : g_we
        assign base_we[p] = bus_wr && (sel == SEL_BASE) && (idx == IDX_W'(p));
        assign active_base[p*WORD_W +: WORD_W] = active[p];
    end

    assign copy_evt = disp_en && vsync;

    fbase_bank #(
        .NUM_PANELS(NUM_PANELS),
        .ALIGN_BITS(ALIGN_BITS)
    ) u_bank (
        .clk   (clk),
        .rst   (rst),
        .we    (base_we),
        .wdata (bus_wdata),
        .load  (copy_evt),
        .shadow(shadow),
        .active(active)
    );

    fbase_status u_stat (
        .clk      (clk),
        .rst      (rst),
        .set      (copy_evt),
        .clr      (bus_wr && (sel == SEL_CLR) && bus_wdata[0]),
        .mask_we  (bus_wr && (sel == SEL_MASK)),
        .mask_wbit(bus_wdata[0]),
        .flag     (flag),
        .mask     (mask),
        .irq      (irq)
    );

    assign base_upd = flag;

    always_comb begin
        case (sel)
            SEL_BASE: bus_rdata = shadow[idx];
            SEL_MASK: bus_rdata = word_t'(mask);
            SEL_STAT: bus_rdata = word_t'(flag);
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/fbase_checker.sv
`timescale 1ns/1ps
module fbase_checker #(
    parameter int NUM_PANELS = 2,
    parameter int ALIGN_BITS = 2,
    parameter int CLR_OFF    = 32
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     bus_wr,
    input logic [7:0]               bus_addr,
    input logic                     clr_bit,
    input logic                     disp_en,
    input logic                     vsync,
    input logic [NUM_PANELS*32-1:0] active_base,
    input logic                     base_upd,
    input logic                     irq
);
    logic low_bits_set;
    logic clr_wr;

    always_comb begin
        low_bits_set = 1'b0;
        for (int p = 0; p < NUM_PANELS; p++)
            low_bits_set = low_bits_set | (|active_base[p*32 +: ALIGN_BITS]);
    end

    assign clr_wr = bus_wr && (bus_addr == 8'(CLR_OFF)) && clr_bit;

    // R2: active addresses stay word aligned
    a_r2_aligned: assert property (@(posedge clk) disable iff (rst) !low_bits_set);

    // R3 and R10: without an enabled vsync the active copies hold
    a_r10_no_copy: assert property (@(posedge clk) disable iff (rst)
        !(disp_en && vsync) |=> $stable(active_base));

    // R6 and R8: an enabled vsync sets the flag, even against a clear
    a_r6_set: assert property (@(posedge clk) disable iff (rst)
        (disp_en && vsync) |=> base_upd);

    // R6: the flag is sticky without a clear
    a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
        (base_upd && !clr_wr) |=> base_upd);

    // R7: a clear without a vsync copy drops the flag
    a_r7_clear: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && !(disp_en && vsync)) |=> !base_upd);

    // R9: the interrupt needs the flag
    a_r9_irq_flag: assert property (@(posedge clk) disable iff (rst) irq |-> base_upd);

    // R10: no flag rise without an enabled vsync
    a_r10_no_set: assert property (@(posedge clk) disable iff (rst)
        (!base_upd && !(disp_en && vsync)) |=> !base_upd);
endmodule

bind fbase_top fbase_checker #(
    .NUM_PANELS(NUM_PANELS),
    .ALIGN_BITS(ALIGN_BITS),
    .CLR_OFF   (CLR_OFF)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .clr_bit    (bus_wdata[0]),
    .disp_en    (disp_en),
    .vsync      (vsync),
    .active_base(active_base),
    .base_upd   (base_upd),
    .irq        (irq)
);

// File: tb/fbase_top_bench.sv
`timescale 1ns/1ps
module fbase_top_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        disp_en;
    logic        vsync;
    logic [63:0] active_base;
    logic        base_upd;
    logic        irq;

    int n_run  = 0;
    int n_fail = 0;

    localparam logic [7:0] A_UP = 8'h10, A_LO = 8'h14, A_MSK = 8'h18,
                           A_STA = 8'h1C, A_CLR = 8'h20;

    always #2 clk = ~clk;

    fbase_top u_fbase_top (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .disp_en(disp_en),
        .vsync(vsync), .active_base(active_base), .base_upd(base_upd), .irq(irq)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulse_vsync();
        @(negedge clk);
        vsync = 1'b1;
        @(negedge clk);
        vsync = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 active", active_base, 64'h0);
        chk("R1 flag", {63'h0, base_upd}, 64'h0);
        chk("R1 irq", {63'h0, irq}, 64'h0);
        rd(A_UP, d);  chk("R1 upper shadow", {32'h0, d}, 64'h0);
        rd(A_LO, d);  chk("R1 lower shadow", {32'h0, d}, 64'h0);
        rd(A_MSK, d); chk("R1 irq enable", {32'h0, d}, 64'h0);
    endtask

    task automatic t_write_shadow();
        logic [31:0] d;
        wr(A_UP, 32'h1234_5677);
        wr(A_LO, 32'hABCD_EF02);
        rd(A_UP, d); chk("R2 R3 upper readback", {32'h0, d}, 64'h1234_5674);
        rd(A_LO, d); chk("R2 R3 lower readback", {32'h0, d}, 64'hABCD_EF00);
        chk("R3 active untouched", active_base, 64'h0);
    endtask

    task automatic t_vsync_copy();
        logic [31:0] d;
        pulse_vsync();
        chk("R4 R2 active after vsync", active_base, 64'hABCD_EF00_1234_5674);
        chk("R6 flag set", {63'h0, base_upd}, 64'h1);
        rd(A_STA, d); chk("R6 status read", {32'h0, d}, 64'h1);
        @(negedge clk); @(negedge clk);
        chk("R6 flag sticky", {63'h0, base_upd}, 64'h1);
    endtask

    task automatic t_clear();
        wr(A_CLR, 32'h0);
        chk("R7 write 0 keeps flag", {63'h0, base_upd}, 64'h1);
        wr(A_CLR, 32'h1);
        chk("R7 write 1 clears flag", {63'h0, base_upd}, 64'h0);
    endtask

    task automatic t_same_cycle();
        logic [31:0] d;
        @(negedge clk);
        vsync = 1'b1; bus_wr = 1'b1; bus_addr = A_UP; bus_wdata = 32'h0BAD_F00C;
        @(negedge clk);
        vsync = 1'b0; bus_wr = 1'b0;
        chk("R5 active keeps old value", active_base, 64'hABCD_EF00_1234_5674);
        rd(A_UP, d); chk("R5 shadow holds new", {32'h0, d}, 64'h0BAD_F00C);
        pulse_vsync();
        chk("R5 new value at next vsync", active_base, 64'hABCD_EF00_0BAD_F00C);
    endtask

    task automatic t_set_beats_clear();
        wr(A_CLR, 32'h1);
        chk("R7 cleared before collision", {63'h0, base_upd}, 64'h0);
        @(negedge clk);
        vsync = 1'b1; bus_wr = 1'b1; bus_addr = A_CLR; bus_wdata = 32'h1;
        @(negedge clk);
        vsync = 1'b0; bus_wr = 1'b0;
        chk("R8 set wins over clear", {63'h0, base_upd}, 64'h1);
    endtask

    task automatic t_irq();
        chk("R9 irq masked", {63'h0, irq}, 64'h0);
        wr(A_MSK, 32'h1);
        chk("R9 irq with flag and enable", {63'h0, irq}, 64'h1);
        wr(A_CLR, 32'h1);
        chk("R9 irq drops with flag", {63'h0, irq}, 64'h0);
        pulse_vsync();
        chk("R9 irq after new vsync", {63'h0, irq}, 64'h1);
        wr(A_MSK, 32'h0);
        chk("R9 irq disabled", {63'h0, irq}, 64'h0);
    endtask

    task automatic t_disabled();
        wr(A_CLR, 32'h1);
        disp_en = 1'b0;
        wr(A_LO, 32'h5555_0000);
        pulse_vsync();
        chk("R10 no copy when disabled", active_base, 64'hABCD_EF00_0BAD_F00C);
        chk("R10 no flag when disabled", {63'h0, base_upd}, 64'h0);
        disp_en = 1'b1;
        pulse_vsync();
        chk("R10 copy resumes", active_base, 64'h5555_0000_0BAD_F00C);
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        disp_en = 1'b1; vsync = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_write_shadow();
        t_vsync_copy();
        t_clear();
        t_same_cycle();
        t_set_beats_clear();
        t_irq();
        t_disabled();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule